// File: doc/BRIEF.md
# Digital potentiometer register controller

This block holds the register file behind a serially controlled 256-tap digital potentiometer. A bus front end, not part of this block, decodes serial frames into a simple parallel port: a 7-bit device address, a register address, write data, and single-cycle write and read strobes. The block returns read data one cycle after a read strobe.

The block drives two outputs: the 8-bit wiper code for the resistor array and a shutdown signal. Code 00h puts the wiper nearest the low terminal and FFh nearest the high terminal. Position rises monotonically with the code.

At power-up the wiper is parked at mid-scale. Once the supply is reported good, the wiper is reloaded from a stored initial value. Register address 0 reaches either the stored initial value or the live wiper, selected by a mode bit in the control register. Storing an initial value also moves the live wiper. The stored bytes are modelled as flops. A busy flag holds off further stored writes for a fixed number of cycles, which models the write time of real non-volatile cells.

Top module: `dpot_regs`

## Requirements
- R1: After reset the wiper output is 80h, and port accesses have no effect. When supply_ok is first sampled high at a clock edge, the wiper output takes the stored initial value (parameter INIT_IVR) one edge later. Accesses are accepted from the edge after that.
- R2: An access is accepted only if dev_addr[1:0] equals pin_sel and dev_addr[6:2] equals the upper five bits of parameter DEV_ID (default 1010000b). A rejected write changes nothing. A rejected read leaves rd_data unchanged.
- R3: With control bit 7 at 0, address 00h reads the stored initial value. A write to 00h stores the value and also copies it to the wiper output.
- R4: With control bit 7 at 1, address 00h reads and writes the live wiper only, and the stored initial value is left unchanged.
- R5: The control register sits at address 10h. Bit 7 selects the mode for address 0. Bit 6 is the run bit and resets to 1. Bit 5 reads the busy flag. Bits 4 to 0 read 0. Writes affect only bits 7 and 6, and the value read after reset is 40h.
- R6: While the run bit is 0, the shutdown output is 1. The wiper register keeps its code throughout, so setting the run bit again restores the previous tap.
- R7: Addresses 01h to 0Eh are fourteen stored general-purpose bytes that read back what was written.
- R8: An accepted write to a stored byte (address 00h in stored mode, or 01h to 0Eh) sets the busy flag for WR_CYCLES edges. The flag reads 1 from the edge after the write through edge WR_CYCLES after it. Stored writes while busy are ignored. Writes to the wiper and to the control register are still accepted while busy.
- R9: Address 0Fh and addresses above 10h read 00h. Writes to them change no register and do not start the busy flag.
- R10: rd_data is registered. It shows the value addressed by a read strobe from the clock edge that samples that strobe, and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply good enough to read stored values |
| pin_sel | input | 2 | Strap value for the low device-address bits |
| dev_addr | input | 7 | Device address of the current access |
| reg_addr | input | 5 | Register address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read data |
| wiper_code | output | 8 | Wiper tap code |
| shutdown | output | 1 | Array open, wiper at low terminal |

## Verification
Writes take effect at the edge that samples the strobe. The bench drives strobes at a falling edge and checks the wiper, shutdown and later reads at the next falling edge. Read data is due one edge after the strobe, so every read check samples rd_data at the falling edge right after that edge. The wiper reload is due two edges after supply_ok first rises, and the bench checks it both before and at that point. The busy flag is probed by reads timed to hit the last busy edge and the first clear edge exactly.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

   // power-up sequencer phases
   typedef enum logic [1:0] {
      PU_PARK = 2'd0,
      PU_LOAD = 2'd1,
      PU_RUN  = 2'd2
   } pu_state_t;

endpackage

// File: rtl/dpot_powerup.sv
module dpot_powerup
   import dpot_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      supply_ok,
   output pu_state_t state
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PU_PARK;
      end else begin
         unique case (state)
            PU_PARK: if (supply_ok) state <= PU_LOAD;
            PU_LOAD: state <= PU_RUN;
            default: state <= PU_RUN;
         endcase
      end
   end

endmodule

// File: rtl/dpot_nvstore.sv
module dpot_nvstore #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_GP    = 14,
   parameter int unsigned WR_CYCLES = 20,
   parameter int unsigned INIT_IVR  = 128,
   parameter int unsigned GPI_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ivr_req,
   input  logic              gp_req,
   input  logic [GPI_W-1:0]  gp_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic              ivr_take,
   output logic [DATA_W-1:0] ivr_q,
   output logic [DATA_W-1:0] gp_rdata,
   output logic              busy
);

   logic              start;
   logic              gp_take;
   logic [DATA_W-1:0] gp_q [NUM_GP];

   assign ivr_take = ivr_req & ~busy;
   assign gp_take  = gp_req & ~busy;
   assign start    = ivr_take | gp_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ivr_q <= DATA_W'(INIT_IVR);
      else if (ivr_take) ivr_q <= wdata;
   end

   for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            gp_q[g] <= '0;
         else if (gp_take && gp_sel == GPI_W'(g))
            gp_q[g] <= wdata;
      end
   end

   always_comb begin
      gp_rdata = '0;
      for (int k = 0; k < NUM_GP; k++) begin
         if (gp_sel == GPI_W'(k)) gp_rdata = gp_q[k];
      end
   end

   if (WR_CYCLES == 1) begin : g_tmr_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy <= 1'b0;
         else        busy <= start;
      end
   end else begin : g_tmr_cnt
      localparam int unsigned CNT_W = $clog2(WR_CYCLES);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(WR_CYCLES - 1);
         end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/dpot_volregs.sv
module dpot_volregs #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PARK_CODE = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_init,
   input  logic [DATA_W-1:0] ivr_q,
   input  logic              ivr_take,
   input  logic              wiper_wr,
   input  logic              acr_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] wiper,
   output logic              vol,
   output logic              run
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    wiper <= DATA_W'(PARK_CODE);
      else if (load_init)            wiper <= ivr_q;
      else if (ivr_take || wiper_wr) wiper <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol <= 1'b0;
         run <= 1'b1;
      end else if (acr_wr) begin
         vol <= wdata[DATA_W-1];
         run <= wdata[DATA_W-2];
      end
   end

endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
   import dpot_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DEV_W     = 7,
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned DEV_ID    = 7'b1010000,
   parameter int unsigned NUM_GP    = 14,
   parameter int unsigned ACR_ADDR  = 16,
   parameter int unsigned WR_CYCLES = 20,
   parameter int unsigned PARK_CODE = 128,
   parameter int unsigned INIT_IVR  = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic [SEL_W-1:0]  pin_sel,
   input  logic [DEV_W-1:0]  dev_addr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] wiper_code,
   output logic              shutdown
);

   localparam int unsigned GPI_W = $clog2(NUM_GP);
   localparam logic [ADDR_W-1:0] A_GP_LAST = ADDR_W'(NUM_GP);
   localparam logic [ADDR_W-1:0] A_ACR     = ADDR_W'(ACR_ADDR);
   localparam logic [DEV_W-1:0]  DEV_FIX   = DEV_W'(DEV_ID);

   if (DATA_W < 3)                    begin : g_bad_data $error("DATA_W too small for control bits"); end
   if (NUM_GP < 2)                    begin : g_bad_gp   $error("NUM_GP must be at least 2"); end
   if (ACR_ADDR <= NUM_GP)            begin : g_bad_acr  $error("ACR_ADDR overlaps stored bytes"); end
   if (ACR_ADDR >= (1 << ADDR_W))     begin : g_bad_aw   $error("ACR_ADDR outside address space"); end
   if (WR_CYCLES < 1)                 begin : g_bad_wc   $error("WR_CYCLES must be at least 1"); end
   if (SEL_W < 1 || SEL_W >= DEV_W)   begin : g_bad_sel  $error("SEL_W out of range"); end
   if (PARK_CODE >= (1 << DATA_W))    begin : g_bad_park $error("PARK_CODE too wide"); end
   if (INIT_IVR >= (1 << DATA_W))     begin : g_bad_init $error("INIT_IVR too wide"); end

   pu_state_t         pu_state;
   logic              ready;
   logic              dev_ok;
   logic              acc_wr, acc_rd;
   logic              is_zero, is_gp, is_acr;
   logic              ivr_take, nv_busy;
   logic              acr_vol, acr_run;
   logic [DATA_W-1:0] ivr_q, gp_rdata, rd_mux, wiper;
   logic [DATA_W-1:0] acr_val;
   logic [GPI_W-1:0]  gp_sel;

   dpot_powerup u_pu (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .state     (pu_state)
   );

   assign ready  = (pu_state == PU_RUN);
   assign dev_ok = (dev_addr[SEL_W-1:0] == pin_sel) &&
                   (dev_addr[DEV_W-1:SEL_W] == DEV_FIX[DEV_W-1:SEL_W]);
   assign acc_wr = wr_en & dev_ok & ready;
   assign acc_rd = rd_en & dev_ok & ready;

   assign is_zero = (reg_addr == '0);
   assign is_gp   = (reg_addr != '0) && (reg_addr <= A_GP_LAST);
   assign is_acr  = (reg_addr == A_ACR);
   assign gp_sel  = GPI_W'(reg_addr - 1'b1);

   dpot_nvstore #(
      .DATA_W    (DATA_W),
      .NUM_GP    (NUM_GP),
      .WR_CYCLES (WR_CYCLES),
      .INIT_IVR  (INIT_IVR),
      .GPI_W     (GPI_W)
   ) u_nv (
      .clk      (clk),
      .rst_n    (rst_n),
      .ivr_req  (acc_wr & is_zero & ~acr_vol),
      .gp_req   (acc_wr & is_gp),
      .gp_sel   (gp_sel),
      .wdata    (wr_data),
      .ivr_take (ivr_take),
      .ivr_q    (ivr_q),
      .gp_rdata (gp_rdata),
      .busy     (nv_busy)
   );

   dpot_volregs #(
      .DATA_W    (DATA_W),
      .PARK_CODE (PARK_CODE)
   ) u_vol (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_init (pu_state == PU_LOAD),
      .ivr_q     (ivr_q),
      .ivr_take  (ivr_take),
      .wiper_wr  (acc_wr & is_zero & acr_vol),
      .acr_wr    (acc_wr & is_acr),
      .wdata     (wr_data),
      .wiper     (wiper),
      .vol       (acr_vol),
      .run       (acr_run)
   );

   assign acr_val = {acr_vol, acr_run, nv_busy, {(DATA_W-3){1'b0}}};

   always_comb begin
      if (is_zero)     rd_mux = acr_vol ? wiper : ivr_q;
      else if (is_gp)  rd_mux = gp_rdata;
      else if (is_acr) rd_mux = acr_val;
      else             rd_mux = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= '0;
      else if (acc_rd) rd_data <= rd_mux;
   end

   assign wiper_code = wiper;
   assign shutdown   = ~acr_run;

endmodule

// File: rtl/dpot_regs_chk.sv
module dpot_regs_chk
   import dpot_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DEV_W     = 7,
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned PARK_CODE = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DEV_W-1:0]  dev_addr,
   input logic [SEL_W-1:0]  pin_sel,
   input logic [4:0]        reg_addr,
   input pu_state_t         pu_state,
   input logic [DATA_W-1:0] wiper_code,
   input logic [DATA_W-1:0] ivr_q,
   input logic              nv_busy,
   input logic              acr_vol,
   input logic [DATA_W-1:0] rd_data
);

   // R1
   park_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pu_state == PU_PARK) |-> (wiper_code == DATA_W'(PARK_CODE)));

   // R1
   load_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pu_state == PU_LOAD) |=> (wiper_code == $past(ivr_q)));

   // R2
   foreign_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pu_state == PU_RUN && dev_addr[SEL_W-1:0] != pin_sel) |=>
      ($stable(wiper_code) && $stable(ivr_q)));

   // R8
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nv_busy) |-> $past(wr_en && pu_state == PU_RUN));

   // R8
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_busy && wr_en && reg_addr == 5'd0 && !acr_vol) |=> $stable(ivr_q));

   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R6
   wiper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pu_state == PU_RUN && !wr_en) |=> $stable(wiper_code));

endmodule

bind dpot_regs dpot_regs_chk #(
   .DATA_W    (DATA_W),
   .DEV_W     (DEV_W),
   .SEL_W     (SEL_W),
   .PARK_CODE (PARK_CODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .dev_addr   (dev_addr),
   .pin_sel    (pin_sel),
   .reg_addr   (reg_addr),
   .pu_state   (pu_state),
   .wiper_code (wiper_code),
   .ivr_q      (ivr_q),
   .nv_busy    (nv_busy),
   .acr_vol    (acr_vol),
   .rd_data    (rd_data)
);

// File: tb/dpot_regs_bench.sv
module dpot_regs_bench;

   localparam int CLK_PERIOD = 10;
   localparam int BUSY_CY    = 8;
   localparam logic [7:0] STORE0 = 8'h3C;

   localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_WIP = 3'd2,
                          OP_SHD = 3'd3, OP_IDLE = 3'd4;
   localparam logic [6:0] D_OK = 7'b1010001, D_BLO = 7'b1010010, D_BHI = 7'b0010001;
   localparam logic [1:0] PINS = 2'b01;

   // entry: {req[3:0], op[2:0], dev[6:0], addr[4:0], data[7:0]}
   localparam int NV = 41;
   localparam logic [26:0] TBL [NV] = '{
      {4'd5, OP_RD,   D_OK,  5'h10, 8'h40},  // R5 reset value
      {4'd3, OP_RD,   D_OK,  5'h00, 8'h3C},  // R3 stored value
      {4'd3, OP_WR,   D_OK,  5'h00, 8'h5A},  // R3
      {4'd3, OP_WIP,  D_OK,  5'h00, 8'h5A},  // R3 copy to wiper
      {4'd8, OP_IDLE, D_OK,  5'h00, 8'd10},
      {4'd3, OP_RD,   D_OK,  5'h00, 8'h5A},  // R3
      {4'd5, OP_WR,   D_OK,  5'h10, 8'hC0},  // R5
      {4'd5, OP_RD,   D_OK,  5'h10, 8'hC0},  // R5
      {4'd4, OP_WR,   D_OK,  5'h00, 8'h11},  // R4
      {4'd4, OP_WIP,  D_OK,  5'h00, 8'h11},  // R4
      {4'd4, OP_RD,   D_OK,  5'h00, 8'h11},  // R4
      {4'd4, OP_WR,   D_OK,  5'h10, 8'h40},  // R4
      {4'd4, OP_RD,   D_OK,  5'h00, 8'h5A},  // R4 stored untouched
      {4'd4, OP_WIP,  D_OK,  5'h00, 8'h11},  // R4
      {4'd2, OP_WR,   D_BLO, 5'h10, 8'h00},  // R2
      {4'd2, OP_SHD,  D_OK,  5'h00, 8'h00},  // R2
      {4'd2, OP_WR,   D_BHI, 5'h00, 8'h99},  // R2
      {4'd2, OP_WIP,  D_OK,  5'h00, 8'h11},  // R2
      {4'd2, OP_RD,   D_OK,  5'h10, 8'h40},  // R2
      {4'd2, OP_RD,   D_BLO, 5'h00, 8'h40},  // R2 rejected read holds
      {4'd7, OP_WR,   D_OK,  5'h01, 8'hA5},  // R7
      {4'd7, OP_IDLE, D_OK,  5'h00, 8'd10},
      {4'd7, OP_WR,   D_OK,  5'h0E, 8'h0E},  // R7
      {4'd7, OP_IDLE, D_OK,  5'h00, 8'd10},
      {4'd7, OP_RD,   D_OK,  5'h01, 8'hA5},  // R7
      {4'd7, OP_RD,   D_OK,  5'h0E, 8'h0E},  // R7
      {4'd9, OP_WR,   D_OK,  5'h0F, 8'hFF},  // R9
      {4'd9, OP_RD,   D_OK,  5'h0F, 8'h00},  // R9
      {4'd9, OP_WR,   D_OK,  5'h12, 8'hFF},  // R9
      {4'd9, OP_RD,   D_OK,  5'h12, 8'h00},  // R9
      {4'd9, OP_RD,   D_OK,  5'h10, 8'h40},  // R9 no busy, no change
      {4'd6, OP_WR,   D_OK,  5'h10, 8'h00},  // R6
      {4'd6, OP_SHD,  D_OK,  5'h00, 8'h01},  // R6
      {4'd6, OP_WIP,  D_OK,  5'h00, 8'h11},  // R6
      {4'd6, OP_RD,   D_OK,  5'h10, 8'h00},  // R6
      {4'd6, OP_WR,   D_OK,  5'h10, 8'h40},  // R6
      {4'd6, OP_SHD,  D_OK,  5'h00, 8'h00},  // R6
      {4'd6, OP_WIP,  D_OK,  5'h00, 8'h11},  // R6 tap restored
      {4'd5, OP_WR,   D_OK,  5'h10, 8'h7F},  // R5
      {4'd5, OP_RD,   D_OK,  5'h10, 8'h40},  // R5 low bits ignored
      {4'd2, OP_RD,   D_OK,  5'h00, 8'h5A}   // R2 stored value survived
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_ok = 1'b0;
   logic [1:0] pin_sel = PINS;
   logic [6:0] dev_addr = D_OK;
   logic [4:0] reg_addr = '0;
   logic [7:0] wr_data = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] rd_data, wiper_code;
   logic       shutdown;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpot_regs #(
      .WR_CYCLES (BUSY_CY),
      .INIT_IVR  (STORE0)
   ) u_dpot_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .supply_ok  (supply_ok),
      .pin_sel    (pin_sel),
      .dev_addr   (dev_addr),
      .reg_addr   (reg_addr),
      .wr_data    (wr_data),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .rd_data    (rd_data),
      .wiper_code (wiper_code),
      .shutdown   (shutdown)
   );

   task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic do_wr(input logic [6:0] dv, input logic [4:0] a, input logic [7:0] d);
      dev_addr = dv; reg_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic [6:0] dv, input logic [4:0] a);
      dev_addr = dv; reg_addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(1, wiper_code, 8'h80);
      check(6, {7'd0, shutdown}, 8'h00);
      check(10, rd_data, 8'h00);
      // R1 accesses before power-up are ignored
      do_wr(D_OK, 5'h10, 8'h00);
      check(1, {7'd0, shutdown}, 8'h00);
      do_rd(D_OK, 5'h10);
      check(1, rd_data, 8'h00);
      // R1 reload timing
      supply_ok = 1'b1;
      @(negedge clk);
      check(1, wiper_code, 8'h80);
      @(negedge clk);
      check(1, wiper_code, STORE0);

      for (int i = 0; i < NV; i++) begin
         logic [26:0] e;
         e = TBL[i];
         unique case (e[22:20])
            OP_WR:  do_wr(e[19:13], e[12:8], e[7:0]);
            OP_RD:  begin do_rd(e[19:13], e[12:8]); check(int'(e[26:23]), rd_data, e[7:0]); end
            OP_WIP: check(int'(e[26:23]), wiper_code, e[7:0]);
            OP_SHD: check(int'(e[26:23]), {7'd0, shutdown}, e[7:0]);
            default: repeat (int'(e[7:0])) @(negedge clk);
         endcase
      end

      // R8 busy window and blocking
      do_wr(D_OK, 5'h01, 8'h33);          // edge k
      do_rd(D_OK, 5'h10);                 // edge k+1
      check(8, rd_data, 8'h60);
      do_wr(D_OK, 5'h02, 8'h77);          // edge k+2, ignored
      do_wr(D_OK, 5'h10, 8'hC0);          // edge k+3, accepted
      repeat (BUSY_CY - 4) @(negedge clk);
      do_rd(D_OK, 5'h10);                 // edge k+N, last busy
      check(8, rd_data, 8'hE0);
      do_rd(D_OK, 5'h10);                 // edge k+N+1, clear
      check(8, rd_data, 8'hC0);
      do_wr(D_OK, 5'h10, 8'h40);
      do_rd(D_OK, 5'h02);
      check(8, rd_data, 8'h00);
      do_rd(D_OK, 5'h01);
      check(7, rd_data, 8'h33);
      // R10 data holds when no read strobe
      repeat (3) @(negedge clk);
      check(10, rd_data, 8'h33);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule